// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the 16x oversampling strobe that a UART's transmitter and receiver use to time their bits. It runs from a reference clock and is programmed with a fixed-point divisor: an integer part of up to 16 bits and a fraction of 6 bits, in units of 1/64. Software computes the divisor as four times the reference frequency divided by the baud rate. The upper bits of that result form the integer part and the low six bits form the fraction.

The fraction is realised by dithering. Each tick period lasts either N or N+1 reference clocks, where N is the integer part. A 6-bit accumulator adds the fraction once per tick. Its carry out stretches the following period by one clock, so over any 64 consecutive ticks after a restart the elapsed time is exactly 64·N + F clocks.

Divisor inputs are captured only on a load strobe. The capture restarts the period counter and clears the accumulator. In normal use the block is disabled, loaded and then enabled again. An integer part of zero stops the ticks.

Top module: `baud_frac_tick`

## Requirements
- R1: After reset the captured divisor is zero and `tick` stays low, even with `en` high, until a load with a nonzero integer part.
- R2: With fraction F = 0 and integer part N ≥ 1, `tick` pulses exactly every N clocks.
- R3: With F > 0, every tick period is N or N+1 clocks. Period k after a restart (k = 1, 2, …) is N+1 exactly when floor(k·F/64) differs from floor((k−1)·F/64).
- R4: Counted from the clock edge that samples `load`, the 64th tick is seen in the clock cycle that ends 64·N + F edges later.
- R5: A captured integer part of zero keeps `tick` low regardless of `en` and the fraction.
- R6: While `en` is low, `tick` stays low. The counter and the accumulator are held at their restart values. When `en` returns high, the first tick follows after N clocks.
- R7: Changes on `div_int` or `div_frac` without `load` have no effect on the tick timing.
- R8: `load` restarts the period counter and the accumulator in the same edge that captures the new divisor, even in the middle of a period. The first tick then follows after N of the new clocks.
- R9: For N ≥ 2, `tick` is never high in two consecutive cycles. For N = 1 and F = 0, `tick` is high in every cycle.
- R10: The first period after a load or a re-enable is never stretched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Tick generation enable |
| load | input | 1 | Captures `div_int`/`div_frac` and restarts the phase |
| div_int | input | INT_W (16) | Integer part of the divisor |
| div_frac | input | FRAC_W (6) | Fractional part of the divisor, 1/64 units |
| tick | output | 1 | One-clock oversampling strobe |

## Verification
The bench builds the block with its default widths: a 16-bit integer part and a 6-bit fraction. It programs small integer parts (0, 1, 2, 3, 4, 5, 6, 7), so that full 64-tick dither cycles take only a few hundred clocks. It uses fractions of 0, 1, 32 and 63, which reach the sparsest and densest carry patterns as well as the alternating one. It also covers the N = 1 case, where a stretched period is the only gap between ticks. A behavioural model computes each period from the floor formula and is compared with `tick` on every clock.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int unsigned BT_INT_W  = 16;
    localparam int unsigned BT_FRAC_W = 6;

    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_WRAP  = 2'd1,
        CNT_STEP  = 2'd2
    } cnt_action_e;

endpackage

// File: rtl/baud_div_shadow.sv
module baud_div_shadow #(
    parameter int unsigned INT_W  = baud_tick_pkg::BT_INT_W,
    parameter int unsigned FRAC_W = baud_tick_pkg::BT_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INT_W-1:0]  int_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [INT_W-1:0]  int_q,
    output logic [FRAC_W-1:0] frac_q
);

    typedef struct packed {
        logic [INT_W-1:0]  n;
        logic [FRAC_W-1:0] f;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.n = int_in;
            sh_d.f = frac_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign int_q  = sh_q.n;
    assign frac_q = sh_q.f;

    // R7: captured divisor only moves on a load strobe
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(int_q) && $stable(frac_q)));

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int unsigned FRAC_W = baud_tick_pkg::BT_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    localparam int unsigned SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {1'b0, st_q.acc} + {1'b0, frac};
        carry = sum[FRAC_W];
        st_d  = st_q;
        if (clr)      st_d.acc = '0;
        else if (adv) st_d.acc = sum[FRAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: accumulator holds between ticks
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(st_q.acc));

    // R10: a restart never stretches the first period
    p_first_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry);

endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
    parameter int unsigned INT_W = baud_tick_pkg::BT_INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [INT_W-1:0] div_n,
    input  logic             stretch,
    output logic             tick
);
    import baud_tick_pkg::*;

    localparam int unsigned LIM_W = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t  st_d, st_q;
    logic [LIM_W-1:0] limit;
    logic        hit;
    cnt_action_e act;

    always_comb begin
        limit = {1'b0, div_n} - LIM_W'(1) + LIM_W'(stretch);
        hit   = ({1'b0, st_q.cnt} == limit);
        tick  = run && hit;
        if (restart || !run) act = CNT_CLEAR;
        else if (hit)        act = CNT_WRAP;
        else                 act = CNT_STEP;
        st_d = st_q;
        case (act)
            CNT_CLEAR: st_d.cnt = '0;
            CNT_WRAP:  st_d.cnt = '0;
            default:   st_d.cnt = st_q.cnt + INT_W'(1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: phase never runs past the longest period N+1
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, st_q.cnt} <= {1'b0, div_n}));

    // R8: a restart leaves the counter at its start
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/baud_frac_tick.sv
module baud_frac_tick #(
    parameter int unsigned INT_W  = baud_tick_pkg::BT_INT_W,
    parameter int unsigned FRAC_W = baud_tick_pkg::BT_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    logic [INT_W-1:0]  n_q;
    logic [FRAC_W-1:0] f_q;
    logic run, clr, adv, stretch;

    always_comb begin
        run = en && (n_q != '0);
        clr = load || !run;
        adv = tick && !load;
    end

    baud_div_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .int_in  (div_int),
        .frac_in (div_frac),
        .int_q   (n_q),
        .frac_q  (f_q)
    );

    baud_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (adv),
        .frac  (f_q),
        .carry (stretch)
    );

    baud_period_cnt #(.INT_W(INT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load),
        .div_n   (n_q),
        .stretch (stretch),
        .tick    (tick)
    );

    // R5: zero integer part silences the output
    p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q == '0) |-> !tick);

    // R6: disabled block emits nothing
    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);

    // R9: back-to-back ticks only when N is one
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || (n_q == INT_W'(1))));

endmodule

// File: tb/sim_baud_frac_tick.sv
module sim_baud_frac_tick;

    localparam int IW = 16;
    localparam int FW = 6;
    localparam int FSCALE = 1 << FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          load = 1'b0;
    logic [IW-1:0] div_int = '0;
    logic [FW-1:0] div_frac = '0;
    logic          tick;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    int m_n = 0, m_f = 0, m_cnt = 0, m_k = 1;

    always #5 clk = ~clk;

    baud_frac_tick u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load     (load),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick     (tick)
    );

    function automatic int ext_of(int k, int f);
        return ((k * f) / FSCALE) - (((k - 1) * f) / FSCALE);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: period k lasts N + ext_of(k, F)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_f = 0; m_cnt = 0; m_k = 1;
        end else if (load) begin
            m_n = int'(div_int); m_f = int'(div_frac); m_cnt = 0; m_k = 1;
        end else if (!(en && m_n != 0)) begin
            m_cnt = 0; m_k = 1;
        end else if (m_cnt == m_n - 1 + ext_of(m_k, m_f)) begin
            m_cnt = 0;
            m_k = (m_k == FSCALE) ? 1 : m_k + 1;
        end else begin
            m_cnt++;
        end
    end

    always @(negedge clk) begin
        bit exp_t;
        cycles++;
        if (rst_n && !finished) begin
            exp_t = en && (m_n != 0) && (m_cnt == m_n - 1 + ext_of(m_k, m_f));
            chk(tick === exp_t, cur_req, int'(tick), int'(exp_t));
        end
    end

    initial begin
        wait (cycles > 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic do_load(input int n, input int f);
        @(posedge clk); #2;
        div_int = IW'(n); div_frac = FW'(f); load = 1'b1;
        @(posedge clk); #2;
        load = 1'b0;
    endtask

    task automatic count_ticks(input int ncyc, output int t);
        t = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (tick) t++;
        end
    endtask

    task automatic to_tick(output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!tick && c < 70000);
    endtask

    task automatic span64(output int c);
        int t;
        c = 0; t = 0;
        while (t < 64 && c < 70000) begin
            @(negedge clk);
            c++;
            if (tick) t++;
        end
    endtask

    initial begin
        int v, w;
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R1 reset", int'(tick), 0);
        @(posedge clk); #2;
        rst_n = 1'b1; en = 1'b1;
        count_ticks(30, v);
        chk(v == 0, "R1 no load", v, 0);

        cur_req = "R2";
        do_load(5, 0);
        span64(v);
        chk(v == 320, "R2 span N=5 F=0", v, 320);
        to_tick(v);
        chk(v == 5, "R2 period", v, 5);

        cur_req = "R4";
        do_load(5, 1);
        span64(v);
        chk(v == 321, "R4 N=5 F=1", v, 321);
        do_load(3, 63);
        span64(v);
        chk(v == 255, "R4 N=3 F=63", v, 255);
        do_load(7, 32);
        span64(v);
        chk(v == 480, "R4 N=7 F=32", v, 480);

        cur_req = "R3";
        do_load(4, 32);
        to_tick(v);
        chk(v == 4, "R10 first period", v, 4);
        to_tick(v);
        chk(v == 5, "R3 stretched period", v, 5);
        to_tick(v);
        chk(v == 4, "R3 plain period", v, 4);

        cur_req = "R9";
        do_load(1, 0);
        count_ticks(10, v);
        chk(v == 10, "R9 N=1 every cycle", v, 10);
        do_load(2, 0);
        count_ticks(10, v);
        chk(v == 5, "R9 N=2", v, 5);
        do_load(1, 63);
        span64(v);
        chk(v == 127, "R9 R4 N=1 F=63", v, 127);

        cur_req = "R5";
        do_load(0, 10);
        count_ticks(100, v);
        chk(v == 0, "R5 zero divisor", v, 0);

        cur_req = "R6";
        do_load(6, 0);
        count_ticks(9, v);
        @(posedge clk); #2;
        en = 1'b0;
        count_ticks(20, v);
        chk(v == 0, "R6 disabled", v, 0);
        @(posedge clk); #2;
        en = 1'b1;
        to_tick(v);
        chk(v == 6, "R6 re-enable", v, 6);

        cur_req = "R7";
        do_load(4, 0);
        to_tick(v);
        @(posedge clk); #2;
        div_int = IW'(9); div_frac = FW'(40);
        to_tick(v);
        to_tick(w);
        chk(w == 4, "R7 unloaded change", w, 4);
        to_tick(w);
        chk(w == 4, "R7 unloaded change again", w, 4);

        cur_req = "R8";
        do_load(4, 0);
        count_ticks(2, v);
        do_load(6, 0);
        to_tick(v);
        chk(v == 6, "R8 mid-period reload", v, 6);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule